// File: doc/BRIEF.md
# Three-Level Masked Event Interrupt Controller

This block gathers single-cycle event pulses from on-chip peripherals into sticky status words. Each status bit stays set until software writes a one to it. Three independent mask groups are laid over the same status words, and each group drives one processor interrupt line, so software can steer any event to any line. Because every group has one mask word per status word, the steering is done bit by bit.

Each line also carries a valid flag and the number of the lowest-numbered event that is both pending and enabled in that group. An interrupt handler can therefore find its source without scanning the status words itself. All status and mask words are reached over a simple word-addressed register bus. Reads of that bus are combinational and writes take effect at the next clock edge.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Reset clears every status bit and every mask bit. After reset every register reads zero, and all interrupt lines and valid flags are low.
- R2: An event pulse on `evt_i[n]` sets status word n/32, bit n%32, at the next clock edge. The bit is set whether or not any mask enables it, and it stays set while no acknowledge write hits it.
- R3: A write to a status word clears each bit where the written data holds a one. Bits where the data holds a zero are left unchanged.
- R4: If an event pulse and an acknowledge for the same bit land in the same cycle, the bit stays set.
- R5: Status word w is at byte offset 4*w (0x00, 0x04, 0x08). Mask word w of group g is at 0x10 + 0x10*g + 4*w. A written mask word reads back unchanged.
- R6: `irq_o[g]` is high exactly while some status word ANDed with the matching mask word of group g is nonzero. Group 0 is the highest-priority line and group 2 the lowest.
- R7: For each group g, `pend_valid_o[g]` equals `irq_o[g]`. While it is high, the 7-bit field `pend_num_o[7*g +: 7]` holds the lowest event number 32*w+b among the bits set in both status and mask of that group.
- R8: Reads of offsets that are not mapped return zero, and writes to them change no status or mask bit. This covers offsets whose low two bits are nonzero, word 3 of any bank, and offsets of 0x40 and above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 96 | Single-cycle event pulses, bit n is event n |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset of the register accessed |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 3 | Interrupt line per mask group |
| pend_valid_o | output | 3 | Group has a pending enabled event |
| pend_num_o | output | 21 | Lowest pending event number, 7 bits per group |

## Verification
The bench builds the block with its default parameters: three status words of 32 bits, three mask groups and an 8-bit offset bus. These values make the extreme event numbers 0, 31, 32, 63, 64 and 95 reachable, and let each of them be routed to each of the three lines. The full 8-bit offset space also lets the bench probe the holes in the register map: the fourth word slot of each bank, misaligned offsets and offsets above the last group. The collision of an event with its own acknowledge is reached with a pulse and a write placed in the same cycle. The lowest-number search is exercised with two enabled events in different words of the same group.

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int WORDS  = 3,
  parameter int WIDTH  = 32,
  parameter int LEVELS = 3,
  parameter int ADDR_W = 8
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic [WORDS*WIDTH-1:0]                      evt_i,
  input  logic                                        wr_en_i,
  input  logic [ADDR_W-1:0]                           addr_i,
  input  logic [WIDTH-1:0]                            wdata_i,
  output logic [WIDTH-1:0]                            rdata_o,
  output logic [LEVELS-1:0]                           irq_o,
  output logic [LEVELS-1:0]                           pend_valid_o,
  output logic [LEVELS*$clog2(WORDS*WIDTH)-1:0]       pend_num_o
);
  localparam int NEV    = WORDS * WIDTH;
  localparam int NUM_W  = $clog2(NEV);
  localparam int GSEL_W = ADDR_W - 4;

  logic [WIDTH-1:0]  stat_q [WORDS];
  logic [WIDTH-1:0]  mask_q [LEVELS][WORDS];
  logic [NEV-1:0]    act    [LEVELS];

  wire [GSEL_W-1:0] gsel = addr_i[ADDR_W-1:4];
  wire [1:0]        wsel = addr_i[3:2];
  wire hit = (addr_i[1:0] == 2'b00) && (wsel <= 2'(WORDS - 1)) &&
             (gsel <= GSEL_W'(LEVELS));

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    wire ack_sel = wr_en_i && hit && (gsel == '0) && (wsel == 2'(w));
    wire [WIDTH-1:0] ack = ack_sel ? wdata_i : '0;
    always_ff @(posedge clk) begin
      if (!rst_n) stat_q[w] <= '0;
      else        stat_q[w] <= (stat_q[w] & ~ack) | evt_i[w*WIDTH +: WIDTH];
    end
  end

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    for (genvar w = 0; w < WORDS; w++) begin : g_mw
      always_ff @(posedge clk) begin
        if (!rst_n)
          mask_q[g][w] <= '0;
        else if (wr_en_i && hit && gsel == GSEL_W'(g + 1) && wsel == 2'(w))
          mask_q[g][w] <= wdata_i;
      end
      assign act[g][w*WIDTH +: WIDTH] = stat_q[w] & mask_q[g][w];
    end

    assign irq_o[g] = |act[g];

    always_comb begin
      pend_valid_o[g]            = 1'b0;
      pend_num_o[g*NUM_W +: NUM_W] = '0;
      for (int i = NEV - 1; i >= 0; i--) begin
        if (act[g][i]) begin
          pend_valid_o[g]              = 1'b1;
          pend_num_o[g*NUM_W +: NUM_W] = NUM_W'(i);
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (hit && wsel == 2'(w)) begin
        if (gsel == '0) rdata_o = stat_q[w];
        for (int g = 0; g < LEVELS; g++)
          if (gsel == GSEL_W'(g + 1)) rdata_o = mask_q[g][w];
      end
    end
  end
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
  parameter int WORDS  = 3,
  parameter int WIDTH  = 32,
  parameter int LEVELS = 3,
  parameter int ADDR_W = 8
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic [WORDS*WIDTH-1:0]                evt_i,
  input logic                                  wr_en_i,
  input logic [ADDR_W-1:0]                     addr_i,
  input logic [WIDTH-1:0]                      rdata_o,
  input logic [LEVELS-1:0]                     irq_o,
  input logic [LEVELS-1:0]                     pend_valid_o,
  input logic [LEVELS*$clog2(WORDS*WIDTH)-1:0] pend_num_o
);
  localparam int NEV   = WORDS * WIDTH;
  localparam int NUM_W = $clog2(NEV);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_o == '0 && pend_valid_o == '0));

  assert_line_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ((irq_o & $past(irq_o)) == $past(irq_o)));

  assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(evt_i[0]) && addr_i == '0) |-> rdata_o[0]);

  assert_valid_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_o == irq_o);

  for (genvar g = 0; g < LEVELS; g++) begin : g_rng
    assert_num_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid_o[g] |-> (int'(pend_num_o[g*NUM_W +: NUM_W]) < NEV));
  end

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i[1:0] != 2'b00) |-> (rdata_o == '0));
endmodule

bind evt_irq_ctrl evt_irq_chk #(
  .WORDS(WORDS), .WIDTH(WIDTH), .LEVELS(LEVELS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .rdata_o(rdata_o), .irq_o(irq_o),
  .pend_valid_o(pend_valid_o), .pend_num_o(pend_num_o)
);

// File: tb/sim_evt_irq_ctrl.sv
`timescale 1ns/1ps
module sim_evt_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] evt = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq, pvalid;
  logic [20:0] pnum;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  evt_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .pend_valid_o(pvalid),
    .pend_num_o(pnum)
  );

  // vector: [8:7] group, [6:0] event number
  localparam logic [8:0] VEC [6] = '{
    {2'd0, 7'd0}, {2'd1, 7'd31}, {2'd2, 7'd32},
    {2'd0, 7'd63}, {2'd1, 7'd64}, {2'd2, 7'd95}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input int n);
    evt = '0; evt[n] = 1'b1;
    @(posedge clk); #1;
    evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 64; a += 4) begin
      rd(8'(a), d);
      check($sformatf("R1 reg %0h after reset", a), d, 32'h0);
    end
    check("R1 irq after reset", {29'b0, irq}, 32'h0);
    check("R1 valid after reset", {29'b0, pvalid}, 32'h0);

    // Vector walk: R2 R5 R6 R7
    for (int k = 0; k < 6; k++) begin
      int g, n;
      logic [7:0] ma;
      g = int'(VEC[k][8:7]);
      n = int'(VEC[k][6:0]);
      ma = 8'(16 + 16*g + 4*(n/32));
      wr(ma, 32'h1 << (n % 32));
      rd(ma, d);
      check($sformatf("R5 mask readback vec %0d", k), d, 32'h1 << (n % 32));
      pulse(n);
      rd(8'(4*(n/32)), d);
      check($sformatf("R2 status set vec %0d", k), d, 32'h1 << (n % 32));
      check($sformatf("R6 irq vec %0d", k), {29'b0, irq}, 32'h1 << g);
      check($sformatf("R7 valid vec %0d", k), {29'b0, pvalid}, 32'h1 << g);
      check($sformatf("R7 num vec %0d", k), {25'b0, pnum[g*7 +: 7]}, 32'(n));
      wr(8'(4*(n/32)), 32'hFFFF_FFFF);
      wr(ma, 32'h0);
      check($sformatf("R3 irq cleared vec %0d", k), {29'b0, irq}, 32'h0);
    end

    // R3: zeros leave bits, ones clear
    pulse(1); pulse(2);
    wr(8'h00, 32'h0);
    rd(8'h00, d); check("R3 zero write keeps", d, 32'h6);
    wr(8'h00, 32'h2);
    rd(8'h00, d); check("R3 one write clears", d, 32'h4);
    wr(8'h00, 32'hFFFF_FFFF);

    // R4: event and ack on same bit
    pulse(37);
    evt[37] = 1'b1; wr_en = 1'b1; addr = 8'h04; wdata = 32'h20;
    @(posedge clk); #1;
    evt = '0; wr_en = 1'b0;
    rd(8'h04, d); check("R4 event beats ack", d, 32'h20);
    wr(8'h04, 32'h20);
    rd(8'h04, d); check("R4 later ack clears", d, 32'h0);

    // R6: masked event sets status, no irq until enabled
    pulse(10);
    rd(8'h00, d); check("R2 masked event latched", d, 32'h400);
    check("R6 no irq while masked", {29'b0, irq}, 32'h0);
    wr(8'h30, 32'h400);
    check("R6 irq on lowest line", {29'b0, irq}, 32'h4);
    wr(8'h00, 32'h400);
    wr(8'h30, 32'h0);

    // R7: lowest of several
    wr(8'h14, 32'h100);
    wr(8'h18, 32'h40);
    evt = '0; evt[70] = 1'b1; evt[40] = 1'b1;
    @(posedge clk); #1; evt = '0;
    check("R7 lowest pending", {25'b0, pnum[6:0]}, 32'd40);
    wr(8'h04, 32'h100);
    check("R7 next pending", {25'b0, pnum[6:0]}, 32'd70);
    wr(8'h08, 32'h40);
    check("R7 valid drops", {29'b0, pvalid}, 32'h0);

    // R8: unmapped offsets
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    rd(8'h0C, d); check("R8 read 0x0C", d, 32'h0);
    rd(8'h40, d); check("R8 read 0x40", d, 32'h0);
    rd(8'h11, d); check("R8 read misaligned", d, 32'h0);
    rd(8'h10, d); check("R8 mask g0w0 untouched", d, 32'h0);
    rd(8'h14, d); check("R8 mask g0w1 untouched", d, 32'h100);
    pulse(3);
    rd(8'h00, d); check("R8 status untouched", d, 32'h8);
    check("R8 no irq", {29'b0, irq}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule